// File: doc/BRIEF.md
# Synchronous Serial Link Master

This block drives a synchronous serial link from the chip side. It makes the serial clock itself, with a high time and a low time that are set separately in system clock cycles. Each bit slot of a frame is one serial clock period. A frame has 26 slots: a frame-marker slot with SYNC high, then 24 data bits sent most significant bit first, then one parity bit. The parity mode is odd or even and is captured at the start of every frame. SDO and SYNC move a programmable one to four system cycles after each rising serial clock edge. This lets the board skew outputs away from the far end's sampling point.

Incoming SDI is sampled once per slot, just after each falling serial clock edge. When the parity slot is sampled, the received word is presented with a parity-error flag and a one-cycle valid strobe. A word offered on the transmit handshake is taken at the start of a frame that carries SYNC. When no word is offered, the NULL word input is sent instead. After enable, the first frame is a lead-in: it carries the NULL word, has no SYNC, and reports nothing received. Clearing the enable parks the serial clock low within one period and silences the link.

Top module: `sync_serial_master`

## Requirements
- R1: A serial clock high phase lasts scale_hi+1 system clock cycles. A low phase lasts scale_lo+1 system clock cycles. Both scale inputs are 5 bits wide.
- R2: A scale value takes effect only at the next phase boundary. A phase in progress always runs to the length loaded when it began.
- R3: Out of reset and while link_en is low, sclk stays low. Within a few cycles of that, sync and sdo are low, and rx_valid and tx_done never pulse. Clearing link_en during a high phase lets that phase complete and then parks sclk low.
- R4: After link_en rises, the first frame carries no SYNC and sends null_word in its data slots. Its receive result is not reported. The first SYNC appears in slot 0 of the second frame, exactly 26 serial clock periods after the lead-in frame began.
- R5: Each frame lasts 26 serial clock periods. Slot 0 has sync=1 and sdo=0. Slots 1 to 24 carry data bits 23 down to 0 on sdo. Slot 25 carries the parity bit. SYNC is low outside slot 0.
- R6: When odd_parity=1, the ones in the 24 data bits plus the parity bit add up to an odd count. When odd_parity=0, they add up to an even count. The mode is captured at each frame start, so a change during a frame applies from the next frame. Received words are checked with the captured mode, and rx_perr=1 flags a mismatch.
- R7: sdo and sync change out_delay+1 system cycles after the system cycle in which sclk rose. out_delay is 2 bits wide, so the delay ranges from 1 to 4.
- R8: A frame that carries SYNC takes tx_word if tx_valid is high at its start, and pulses tx_done for one cycle. Otherwise it sends null_word. tx_valid is never consumed by the lead-in frame.
- R9: sdi is sampled in the first system cycle of each sclk low phase. Samples from slots 1 to 24 form rx_word, most significant bit first. The sample from slot 25 is the parity bit. In the cycle after the slot 25 sample, rx_valid pulses for one cycle with rx_word and rx_perr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | Link enable |
| scale_hi | input | 5 | Serial clock high time minus one, in system cycles |
| scale_lo | input | 5 | Serial clock low time minus one, in system cycles |
| odd_parity | input | 1 | 1 selects odd parity, 0 selects even parity |
| out_delay | input | 2 | Extra output delay after the rising serial clock edge |
| null_word | input | 24 | Word sent when nothing is offered |
| tx_valid | input | 1 | A transmit word is offered |
| tx_word | input | 24 | Offered transmit word |
| sdi | input | 1 | Serial data in |
| tx_done | output | 1 | One-cycle strobe: offered word taken |
| sclk | output | 1 | Serial clock |
| sync | output | 1 | Frame marker |
| sdo | output | 1 | Serial data out |
| rx_word | output | 24 | Last received word |
| rx_perr | output | 1 | Parity error on the last received word |
| rx_valid | output | 1 | One-cycle strobe for rx_word and rx_perr |

## Verification
The serial clock goes high in the cycle after its counter expires. sdo and sync follow out_delay+1 cycles after that, so they are read at the next sclk fall. Every vector keeps out_delay no larger than scale_hi, which guarantees they have settled by then. rx_valid is due exactly one cycle after the sclk fall of the parity slot, and the bench checks it in that cycle and no other. Phase lengths are counted in whole cycles between sclk transitions seen at the falling system clock edge. The SYNC delay is measured from the cycle in which sclk was first seen high.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  // strobes produced by the clock generator, one system cycle wide
  typedef struct packed {
    logic rise;
    logic fall;
  } ssm_edge_t;

  localparam int MARK_SLOTS   = 1;
  localparam int PARITY_SLOTS = 1;
endpackage

// File: rtl/ssm_clkgen.sv
module ssm_clkgen
  import ssm_pkg::*;
#(
  parameter int SCALE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [SCALE_W-1:0] scale_hi,
  input  logic [SCALE_W-1:0] scale_lo,
  output logic               sclk_o,
  output ssm_edge_t          edge_o
);
  logic [SCALE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_o <= 1'b0;
      cnt    <= '0;
      edge_o <= '0;
    end else begin
      edge_o <= '0;
      if (!sclk_o && !en) begin
        cnt <= scale_lo;               // parked low, phase length tracks input
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (sclk_o) begin
        sclk_o      <= 1'b0;
        edge_o.fall <= 1'b1;
        cnt         <= scale_lo;
      end else begin
        sclk_o      <= 1'b1;
        edge_o.rise <= 1'b1;
        cnt         <= scale_hi;
      end
    end
  end

  // checker: high phase length against the scale present when it began
  logic [SCALE_W:0]   ph_cnt;
  logic [SCALE_W-1:0] ph_lim;
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_cnt <= '0;
      ph_lim <= '0;
    end else begin
      ph_cnt <= (edge_o.rise || edge_o.fall) ? (SCALE_W+1)'(1) : ph_cnt + 1'b1;
      if (!sclk_o) ph_lim <= scale_hi;
    end
  end

  assert_high_len_R1: assert property (@(posedge clk) disable iff (rst)
    edge_o.fall |-> (ph_cnt == {1'b0, ph_lim} + 1'b1));
  assert_park_low_R3: assert property (@(posedge clk) disable iff (rst)
    (!en && !sclk_o) |=> !sclk_o);
endmodule

// File: rtl/ssm_outdly.sv
module ssm_outdly #(
  parameter int DLY_W = 2,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DLY_W-1:0] sel,
  input  logic [LANES-1:0] d_i,
  output logic [LANES-1:0] q_o
);
  localparam int DEPTH = (1 << DLY_W) - 1;

  logic [LANES-1:0] stg [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) stg[g] <= rst ? '0 : d_i;
    end else begin : g_tail
      always_ff @(posedge clk) stg[g] <= rst ? '0 : stg[g-1];
    end
  end

  always_comb begin
    if (sel == '0) q_o = d_i;
    else           q_o = stg[sel - 1'b1];
  end

  assert_tap1_R7: assert property (@(posedge clk) disable iff (rst)
    (sel == DLY_W'(1)) |-> (q_o == $past(d_i)));
  assert_tap2_R7: assert property (@(posedge clk) disable iff (rst)
    (sel == DLY_W'(2)) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/ssm_frame.sv
module ssm_frame
  import ssm_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  ssm_edge_t         edge_i,
  input  logic              odd_par,
  input  logic [DATA_W-1:0] null_word,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              sdi,
  output logic              raw_sync,
  output logic              raw_sdo,
  output logic              tx_done,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_perr,
  output logic              rx_valid
);
  localparam int SLOTS = MARK_SLOTS + DATA_W + PARITY_SLOTS;
  localparam int POS_W = $clog2(SLOTS);
  localparam logic [POS_W-1:0] LAST  = POS_W'(SLOTS - 1);
  localparam logic [POS_W-1:0] FIRST = POS_W'(MARK_SLOTS);

  logic [POS_W-1:0]  pos;
  logic              active, first, lead, par_odd, tx_par;
  logic [DATA_W-1:0] txsh, rxsh;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pos <= '0; active <= 1'b0; first <= 1'b1; lead <= 1'b1;
      par_odd <= 1'b1; tx_par <= 1'b0; txsh <= '0; rxsh <= '0;
      raw_sync <= 1'b0; raw_sdo <= 1'b0; tx_done <= 1'b0;
      rx_word <= '0; rx_perr <= 1'b0; rx_valid <= 1'b0;
    end else begin
      tx_done  <= 1'b0;
      rx_valid <= 1'b0;
      if (edge_i.rise) begin
        if (!active || pos == LAST) begin
          pos      <= '0;
          active   <= 1'b1;
          first    <= 1'b0;
          lead     <= first;
          par_odd  <= odd_par;
          raw_sync <= !first;
          raw_sdo  <= 1'b0;
          if (!first && tx_valid) begin
            txsh    <= tx_word;
            tx_par  <= ^tx_word ^ odd_par;
            tx_done <= 1'b1;
          end else begin
            txsh    <= null_word;
            tx_par  <= ^null_word ^ odd_par;
          end
        end else begin
          pos      <= pos + 1'b1;
          raw_sync <= 1'b0;
          if (pos == LAST - 1'b1) begin
            raw_sdo <= tx_par;
          end else begin
            raw_sdo <= txsh[DATA_W-1];
            txsh    <= txsh << 1;
          end
        end
      end
      if (edge_i.fall && active) begin
        if (pos >= FIRST && pos < LAST) rxsh <= {rxsh[DATA_W-2:0], sdi};
        if (pos == LAST) begin
          rx_word  <= rxsh;
          rx_perr  <= ^rxsh ^ sdi ^ par_odd;
          rx_valid <= !lead;
        end
      end
    end
  end

  assert_take_R8: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> $past(tx_valid));
  assert_rx_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  assert_mark_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(raw_sync) |-> $past(edge_i.rise));
  assert_mark_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    raw_sync |-> !raw_sdo);
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
  import ssm_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int SCALE_W = 5,
  parameter int DLY_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               link_en,
  input  logic [SCALE_W-1:0] scale_hi,
  input  logic [SCALE_W-1:0] scale_lo,
  input  logic               odd_parity,
  input  logic [DLY_W-1:0]   out_delay,
  input  logic [DATA_W-1:0]  null_word,
  input  logic               tx_valid,
  input  logic [DATA_W-1:0]  tx_word,
  input  logic               sdi,
  output logic               tx_done,
  output logic               sclk,
  output logic               sync,
  output logic               sdo,
  output logic [DATA_W-1:0]  rx_word,
  output logic               rx_perr,
  output logic               rx_valid
);
  ssm_edge_t  edges;
  logic       raw_sync, raw_sdo;
  logic [1:0] lanes;

  ssm_clkgen #(.SCALE_W(SCALE_W)) u_clk (
    .clk(clk), .rst(rst), .en(link_en),
    .scale_hi(scale_hi), .scale_lo(scale_lo),
    .sclk_o(sclk), .edge_o(edges)
  );

  ssm_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .en(link_en), .edge_i(edges),
    .odd_par(odd_parity), .null_word(null_word),
    .tx_valid(tx_valid), .tx_word(tx_word), .sdi(sdi),
    .raw_sync(raw_sync), .raw_sdo(raw_sdo), .tx_done(tx_done),
    .rx_word(rx_word), .rx_perr(rx_perr), .rx_valid(rx_valid)
  );

  ssm_outdly #(.DLY_W(DLY_W), .LANES(2)) u_dly (
    .clk(clk), .rst(rst), .sel(out_delay),
    .d_i({raw_sync, raw_sdo}), .q_o(lanes)
  );

  assign sync = lanes[1];
  assign sdo  = lanes[0];
endmodule

// File: tb/sync_serial_master_test.sv
module sync_serial_master_test;
  logic        clk = 1'b0, rst = 1'b1, link_en = 1'b0;
  logic [4:0]  scale_hi = '0, scale_lo = '0;
  logic        odd_parity = 1'b1, tx_valid = 1'b0, sdi = 1'b0;
  logic [1:0]  out_delay = '0;
  logic [23:0] null_word = '0, tx_word = '0;
  logic        tx_done, sclk, sync, sdo, rx_perr, rx_valid;
  logic [23:0] rx_word;

  always #5 clk = ~clk;

  sync_serial_master uut (
    .clk(clk), .rst(rst), .link_en(link_en), .scale_hi(scale_hi), .scale_lo(scale_lo),
    .odd_parity(odd_parity), .out_delay(out_delay), .null_word(null_word),
    .tx_valid(tx_valid), .tx_word(tx_word), .sdi(sdi), .tx_done(tx_done),
    .sclk(sclk), .sync(sync), .sdo(sdo), .rx_word(rx_word), .rx_perr(rx_perr),
    .rx_valid(rx_valid)
  );

  typedef struct packed {
    logic [4:0]  h, l;
    logic        odd;
    logic [1:0]  dly;
    logic [23:0] tx, nul, rxd;
    logic        flip, mchg;
  } vec_t;

  // out_delay never exceeds scale_hi, so sdo/sync have settled at each sclk fall
  localparam vec_t VEC [6] = '{
    '{5'd1,  5'd1,  1'b1, 2'd1, 24'hA5C3F0, 24'h000000, 24'h123456, 1'b0, 1'b0},
    '{5'd3,  5'd2,  1'b0, 2'd3, 24'hFFFFFF, 24'h5A5A5A, 24'h800001, 1'b1, 1'b0},
    '{5'd2,  5'd0,  1'b1, 2'd2, 24'h000001, 24'hFFFFFF, 24'h000000, 1'b0, 1'b1},
    '{5'd0,  5'd3,  1'b0, 2'd0, 24'h7E8001, 24'h0F0F0F, 24'hFFFFFF, 1'b0, 1'b0},
    '{5'd4,  5'd4,  1'b1, 2'd1, 24'h3C3C3C, 24'hC00003, 24'hDEAD01, 1'b1, 1'b1},
    '{5'd31, 5'd31, 1'b0, 2'd3, 24'h600DF0, 24'h010203, 24'hB00B00, 1'b0, 1'b0}
  };

  int checks = 0, fails = 0, wd = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", wd);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // ---------------- frame monitor ----------------
  logic [23:0] cur_tx = '0, cur_sdi = '0, lead_cap = '0, exp_w = '0;
  logic        cur_flip = 1'b0, fr_odd = 1'b1, sclk_q = 1'b0, sync_q = 1'b0;
  logic [24:0] cap = '0;
  int cyc = 0, run = 0, hi_len = 0, lo_len = 0, rise_cyc = 0, falls = 0;
  int slot = 0, frames = 0, rxv_pre = 0, txd = 0;
  bit in_frame = 0, seen_sync = 0, rx_due = 0;

  always @(negedge clk) begin
    cyc++;
    if (sclk == sclk_q) run++;
    else begin
      if (sclk_q) hi_len = run; else lo_len = run;
      run = 1;
    end
    if (rx_due) begin
      chk("R9 rx_valid", rx_valid, 1);
      chk("R9 rx_word", rx_word, cur_sdi);
      chk("R6 rx_perr", rx_perr, cur_flip);
      rx_due = 0;
    end
    if (!link_en) begin
      falls = 0; in_frame = 0; seen_sync = 0; frames = 0; rxv_pre = 0; txd = 0; sdi = 1'b0;
    end else begin
      if (tx_done) txd++;
      if (rx_valid && !seen_sync) rxv_pre++;
      if (sclk && !sclk_q) rise_cyc = cyc;
      if (sync && !sync_q) chk("R7 sync delay", cyc - rise_cyc, out_delay + 1);
      if (!sclk && sclk_q) begin
        falls++;
        if (sync) begin
          if (!seen_sync) begin
            chk("R4 periods before first sync", falls - 1, 26);
            chk("R4 lead-in word", lead_cap, null_word);
            chk("R4 no rx during lead-in", rxv_pre, 0);
          end
          seen_sync = 1; in_frame = 1; slot = 0; fr_odd = odd_parity;
          exp_w = (frames == 0) ? cur_tx : null_word;
        end else if (in_frame) begin
          slot++;
        end else if (!seen_sync && falls >= 2 && falls <= 25) begin
          lead_cap[25-falls] = sdo;
        end
        if (in_frame && slot >= 1 && slot <= 25) cap[25-slot] = sdo;
        if (in_frame && slot >= 1 && slot <= 24) sdi = cur_sdi[24-slot];
        else if (in_frame && slot == 25)         sdi = (^cur_sdi) ^ fr_odd ^ cur_flip;
        else                                     sdi = 1'b0;
        if (in_frame && slot == 25) begin
          chk(frames == 0 ? "R8 offered word sent" : "R8 null word sent", cap[24:1], exp_w);
          chk("R6 parity bit", cap[0], (^exp_w) ^ fr_odd);
          chk("R1 high phase", hi_len, scale_hi + 1);
          chk("R1 low phase", lo_len, scale_lo + 1);
          rx_due = 1; in_frame = 0; frames++;
        end
      end
    end
    sclk_q = sclk; sync_q = sync;
  end

  // ---------------- stimulus ----------------
  task automatic run_vec(input vec_t v);
    bit flipped = 0;
    scale_hi = v.h; scale_lo = v.l; odd_parity = v.odd; out_delay = v.dly;
    null_word = v.nul; tx_word = v.tx; cur_tx = v.tx; cur_sdi = v.rxd; cur_flip = v.flip;
    tx_valid = 1'b1;
    repeat (3) @(negedge clk);
    link_en = 1'b1;
    while (frames < 2) begin
      @(negedge clk);
      if (tx_done) tx_valid = 1'b0;
      if (v.mchg && seen_sync && !flipped) begin
        odd_parity = ~odd_parity;   // R6: takes effect from the next frame
        flipped = 1;
      end
    end
    chk("R8 one word taken", txd, 1);
    repeat (3) @(negedge clk);
    link_en = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  task automatic wait_rise();
    logic p = sclk;
    forever begin
      @(negedge clk);
      if (sclk && !p) break;
      p = sclk;
    end
  endtask

  initial begin
    int n, bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 reset sclk", sclk, 0);
    chk("R3 reset sync", sync, 0);
    chk("R3 reset sdo", sdo, 0);
    chk("R3 reset rx_valid", rx_valid, 0);
    chk("R3 reset tx_done", tx_done, 0);
    bad = 0;
    scale_hi = 5'd1; scale_lo = 5'd1;
    repeat (30) begin
      @(negedge clk);
      if (sclk || sync || sdo) bad++;
    end
    chk("R3 idle while disabled", bad, 0);

    foreach (VEC[i]) run_vec(VEC[i]);

    // R2: scale change during a high phase applies from the next one
    scale_hi = 5'd5; scale_lo = 5'd2; out_delay = 2'd0;
    repeat (3) @(negedge clk);
    link_en = 1'b1;
    wait_rise();
    scale_hi = 5'd1;
    n = 1;
    @(negedge clk);
    while (sclk) begin n++; @(negedge clk); end
    chk("R2 phase in progress kept", n, 6);
    wait_rise();
    n = 1;
    @(negedge clk);
    while (sclk) begin n++; @(negedge clk); end
    chk("R2 new scale applied", n, 2);
    link_en = 1'b0;
    repeat (20) @(negedge clk);

    // R3: disable during a high phase
    scale_hi = 5'd4; scale_lo = 5'd2;
    repeat (3) @(negedge clk);
    link_en = 1'b1;
    wait_rise();
    @(negedge clk);
    link_en = 1'b0;
    n = 0;
    while (sclk) begin @(negedge clk); n++; end
    chk("R3 high phase completes then stops", n, 4);
    repeat (5) @(negedge clk);
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (sclk || sync || sdo || rx_valid || tx_done) bad++;
    end
    chk("R3 silent after disable", bad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule